// File: doc/BRIEF.md
# CAN Bus Idle Monitor

This block decides when a CAN controller may regard the bus as idle. It watches the bus level taken at each bit-sample point, counts runs of consecutive recessive samples, and treats every run of eleven as one bus-free sequence. It then drives the two status flags that software sees as the receive flag and the transmit flag.

The flags carry four meanings. When both are 0, the bus is idle. When only the receive flag is 1, a reception is in progress. When only the transmit flag is 1, a transmission is in progress. When both are 1, the controller is waiting to become idle.

Recovery works in two modes:
- After a system reset, a single bus-free sequence is enough to reach idle.
- After a bus-off event, 128 bus-free sequences must be counted before idle is reached. The block then gives a one-cycle pulse to mark that recovery is complete.

The protocol engine supplies the bus-off pulse and the frame start and end strobes.

Top module: `can_idle_monitor`

## Requirements
- R1: While reset is asserted and right after it, `rx_status_o` and `tx_status_o` are both 1 and `recovered_o` is 0.
- R2: A bus-free sequence is 11 consecutive samples with `bus_level_i`=1 (1 = recessive), each taken on a cycle with `bit_strobe_i`=1. After reset, the flags read 00 in the cycle after the strobe that completes the first sequence.
- R3: A strobed sample with `bus_level_i`=0 (dominant) restarts the recessive run from zero. Cycles without `bit_strobe_i` neither advance nor clear the run, whatever the bus level.
- R4: A `bus_off_i` pulse makes both flags read 1 from the next cycle. It restarts both the sequence count and the recessive run, even while a recovery is under way. It takes priority over a sequence that completes in the same cycle.
- R5: After a bus-off event, the flags stay at 11 until the 128th bus-free sequence has been counted, and read 00 in the cycle after it. Back-to-back runs of 22 recessive samples count as two sequences.
- R6: `recovered_o` is 1 for exactly one cycle: the cycle after the 128th sequence following bus-off. It stays 0 on exit from the post-reset wait.
- R7: When idle, `rx_start_i` makes the flags read rx=1, tx=0 from the next cycle, and `rx_end_i` returns the receive flag to 0.
- R8: When idle, `tx_start_i` makes the flags read rx=0, tx=1 from the next cycle, and `tx_end_i` returns the transmit flag to 0.
- R9: Frame starts and ends have no effect while the block is waiting. A start for one direction is ignored while the other direction's frame is active, so 11 never appears outside waiting. If both starts arrive together from idle, the receive start wins. A start in the same cycle as an end for the same direction leaves that flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_strobe_i | input | 1 | High for one cycle at each bit-sample point |
| bus_level_i | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| bus_off_i | input | 1 | One-cycle bus-off event pulse |
| rx_start_i | input | 1 | Start of a received frame |
| rx_end_i | input | 1 | End of a received frame |
| tx_start_i | input | 1 | Start of a transmitted frame |
| tx_end_i | input | 1 | End of a transmitted frame |
| rx_status_o | output | 1 | Receive status flag |
| tx_status_o | output | 1 | Transmit status flag |
| recovered_o | output | 1 | One-cycle pulse when bus-off recovery completes |

## Verification
The recessive-run counter is driven with three kinds of input:
- A run of ten recessive samples broken by a dominant one, then eleven clean samples. This separates "eleven in a row" from "eleven in total".
- Strobes spaced by idle cycles that carry a dominant level. This shows that only strobed samples matter.
- Long unbroken recessive stretches. These show whether back-to-back sequences are counted separately.

Bus-off recovery is run three ways:
- Interrupted by a second bus-off after a few sequences.
- Completed after exactly 128 sequences, with a check after 127 to pin the count.
- Hit by a bus-off on the very strobe that would have completed a sequence, which tests priority.

Frame strobes are tried while waiting, while the other direction is busy, simultaneously from idle, and together with their own end strobe.

// File: rtl/can_idle_pkg.sv
package can_idle_pkg;
  typedef enum logic [1:0] {
    MODE_BOOT_WAIT   = 2'd0,
    MODE_BUSOFF_WAIT = 2'd1,
    MODE_ACTIVE      = 2'd2
  } mon_mode_e;
endpackage

// File: rtl/can_free_run.sv
module can_free_run #(
  parameter int unsigned FREE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic level_i,
  input  logic clear_i,
  output logic seq_o
);
  localparam int unsigned RW = (FREE_BITS > 1) ? $clog2(FREE_BITS) : 1;
  localparam logic [RW-1:0] LAST = RW'(FREE_BITS - 1);

  logic [RW-1:0] run_q;
  logic          at_last;

  assign at_last = (run_q == LAST);
  assign seq_o   = strobe_i & level_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (clear_i) begin
      run_q <= '0;
    end else if (strobe_i) begin
      // restart after a dominant sample or a completed sequence
      if (!level_i || at_last) run_q <= '0;
      else                     run_q <= run_q + 1'b1;
    end
  end

  // R3
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= LAST);
  // R3
  dominant_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !level_i) |=> (run_q == '0));
  // R3
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !clear_i) |=> $stable(run_q));
endmodule

// File: rtl/can_seq_count.sv
module can_seq_count #(
  parameter int unsigned SEQS = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  input  logic seq_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(SEQS + 1);
  localparam logic [CW-1:0] LAST = CW'(SEQS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = en_i & seq_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (en_i && seq_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R4
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/can_status_ctl.sv
module can_status_ctl
  import can_idle_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_off_i,
  input  logic seq_i,
  input  logic done_i,
  input  logic rx_start_i,
  input  logic rx_end_i,
  input  logic tx_start_i,
  input  logic tx_end_i,
  output logic count_en_o,
  output logic rx_o,
  output logic tx_o,
  output logic recovered_o
);
  mon_mode_e mode_q, mode_d;
  logic rx_q, rx_d, tx_q, tx_d, rec_q, rec_d;
  logic rx_take, tx_take, waiting;

  assign waiting    = (mode_q != MODE_ACTIVE);
  assign count_en_o = (mode_q == MODE_BUSOFF_WAIT);
  assign rx_o       = waiting | rx_q;
  assign tx_o       = waiting | tx_q;
  assign recovered_o = rec_q;

  // one frame direction at a time; receive wins a tie
  assign rx_take = rx_start_i & ~tx_q;
  assign tx_take = tx_start_i & ~rx_q & ~rx_take;

  always_comb begin
    mode_d = mode_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    rec_d  = 1'b0;
    if (bus_off_i) begin
      mode_d = MODE_BUSOFF_WAIT;
      rx_d   = 1'b0;
      tx_d   = 1'b0;
    end else begin
      unique case (mode_q)
        MODE_BOOT_WAIT: begin
          if (seq_i) mode_d = MODE_ACTIVE;
        end
        MODE_BUSOFF_WAIT: begin
          if (done_i) begin
            mode_d = MODE_ACTIVE;
            rec_d  = 1'b1;
          end
        end
        MODE_ACTIVE: begin
          if (rx_take)       rx_d = 1'b1;
          else if (rx_end_i) rx_d = 1'b0;
          if (tx_take)       tx_d = 1'b1;
          else if (tx_end_i) tx_d = 1'b0;
        end
        default: mode_d = MODE_BOOT_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_BOOT_WAIT;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
      rec_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      rec_q  <= rec_d;
    end
  end

  // R4
  busoff_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_i |=> (rx_o && tx_o && mode_q == MODE_BUSOFF_WAIT));
  // R9
  one_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ACTIVE) |-> !(rx_q && tx_q));
  // R6
  rec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovered_o |=> !recovered_o);
  // R6
  rec_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BUSOFF_WAIT && !bus_off_i && !done_i) |=> !recovered_o);
  // R2
  boot_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BOOT_WAIT && seq_i && !bus_off_i) |=> (!rx_o && !tx_o));
  // R9
  wait_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting && !seq_i && !done_i && !bus_off_i) |=> (rx_o && tx_o));
endmodule

// File: rtl/can_idle_monitor.sv
module can_idle_monitor #(
  parameter int unsigned FREE_BITS   = 11,
  parameter int unsigned RESUME_SEQS = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_strobe_i,
  input  logic bus_level_i,
  input  logic bus_off_i,
  input  logic rx_start_i,
  input  logic rx_end_i,
  input  logic tx_start_i,
  input  logic tx_end_i,
  output logic rx_status_o,
  output logic tx_status_o,
  output logic recovered_o
);
  logic seq_w, done_w, count_en_w;

  can_free_run #(.FREE_BITS(FREE_BITS)) u_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (bit_strobe_i),
    .level_i  (bus_level_i),
    .clear_i  (bus_off_i),
    .seq_o    (seq_w)
  );

  can_seq_count #(.SEQS(RESUME_SEQS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (bus_off_i),
    .en_i    (count_en_w),
    .seq_i   (seq_w),
    .done_o  (done_w)
  );

  can_status_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_off_i   (bus_off_i),
    .seq_i       (seq_w),
    .done_i      (done_w),
    .rx_start_i  (rx_start_i),
    .rx_end_i    (rx_end_i),
    .tx_start_i  (tx_start_i),
    .tx_end_i    (tx_end_i),
    .count_en_o  (count_en_w),
    .rx_o        (rx_status_o),
    .tx_o        (tx_status_o),
    .recovered_o (recovered_o)
  );

  // R1
  reset_flags_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (rx_status_o && tx_status_o && !recovered_o));
endmodule

// File: tb/sim_can_idle_monitor.sv
module sim_can_idle_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 0, level = 0, bus_off = 0;
  logic rx_start = 0, rx_end = 0, tx_start = 0, tx_end = 0;
  logic rx_o, tx_o, rec_o;

  int checks = 0, failures = 0;
  string phase = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  can_idle_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_strobe_i(strobe), .bus_level_i(level),
    .bus_off_i(bus_off), .rx_start_i(rx_start), .rx_end_i(rx_end),
    .tx_start_i(tx_start), .tx_end_i(tx_end),
    .rx_status_o(rx_o), .tx_status_o(tx_o), .recovered_o(rec_o)
  );

  // reference model: mode 0 boot wait, 1 bus-off wait, 2 active
  int m_run = 0, m_seqs = 0, m_mode = 0;
  bit m_rx = 0, m_tx = 0, m_rec = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_seqs = 0; m_mode = 0; m_rx = 0; m_tx = 0; m_rec = 0;
    end else begin
      bit free, ra, ta;
      free = strobe && level && (m_run == 10);
      if (bus_off) m_run = 0;
      else if (strobe) m_run = (!level || m_run == 10) ? 0 : m_run + 1;
      m_rec = 0;
      if (bus_off) begin
        m_mode = 1; m_seqs = 0; m_rx = 0; m_tx = 0;
      end else if (m_mode == 0) begin
        if (free) m_mode = 2;
      end else if (m_mode == 1) begin
        if (free) begin
          if (m_seqs == 127) begin m_mode = 2; m_rec = 1; m_seqs = 0; end
          else m_seqs++;
        end
      end else begin
        ra = rx_start && !m_tx;
        ta = tx_start && !m_rx && !ra;
        m_rx = ra ? 1'b1 : (rx_end ? 1'b0 : m_rx);
        m_tx = ta ? 1'b1 : (tx_end ? 1'b0 : m_tx);
      end
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({phase, " rx"}, rx_o, (m_mode != 2) || m_rx);
      chk({phase, " tx"}, tx_o, (m_mode != 2) || m_tx);
      chk({phase, " rec"}, rec_o, m_rec);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one strobed sample, idle gap cycles carry the opposite level
  task automatic send_bit(logic lv, int gap);
    @(negedge clk); strobe = 1; level = lv;
    @(negedge clk); strobe = 0; level = ~lv;
    cyc(gap);
  endtask

  task automatic send_seq(int n);
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 11; b++) send_bit(1'b1, 0);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: bus_off = 1;
      1: rx_start = 1;
      2: rx_end = 1;
      3: tx_start = 1;
      default: tx_end = 1;
    endcase
    @(negedge clk);
    bus_off = 0; rx_start = 0; rx_end = 0; tx_start = 0; tx_end = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    phase = "R1";
    chk("R1 reset rx", rx_o, 1'b1);
    chk("R1 reset tx", tx_o, 1'b1);
    chk("R1 reset rec", rec_o, 1'b0);
    rst_n = 1;
    cyc(2);
    chk("R1 after reset rx", rx_o, 1'b1);

    phase = "R9";
    pulse(1); pulse(4);
    chk("R9 start ignored while waiting rx", rx_o, 1'b1);

    phase = "R3";
    for (int i = 0; i < 10; i++) send_bit(1'b1, 2);
    send_bit(1'b0, 0);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1);
    chk("R3 broken run still waiting", tx_o, 1'b1);
    phase = "R2";
    send_bit(1'b1, 0);
    chk("R2 idle after one sequence rx", rx_o, 1'b0);
    chk("R2 idle after one sequence tx", tx_o, 1'b0);
    chk("R6 no pulse on boot exit", rec_o, 1'b0);

    phase = "R7";
    pulse(1);
    chk("R7 receiving rx", rx_o, 1'b1);
    chk("R7 receiving tx", tx_o, 1'b0);
    phase = "R9";
    pulse(3);
    chk("R9 tx start ignored during rx", tx_o, 1'b0);
    phase = "R7";
    pulse(2);
    chk("R7 rx end", rx_o, 1'b0);
    phase = "R8";
    pulse(3);
    chk("R8 transmitting tx", tx_o, 1'b1);
    chk("R8 transmitting rx", rx_o, 1'b0);
    @(negedge clk); tx_start = 1; tx_end = 1;
    @(negedge clk); tx_start = 0; tx_end = 0;
    chk("R9 start with end keeps tx", tx_o, 1'b1);
    pulse(4);
    chk("R8 tx end", tx_o, 1'b0);
    phase = "R9";
    @(negedge clk); rx_start = 1; tx_start = 1;
    @(negedge clk); rx_start = 0; tx_start = 0;
    chk("R9 tie rx wins rx", rx_o, 1'b1);
    chk("R9 tie rx wins tx", tx_o, 1'b0);
    pulse(2);

    phase = "R4";
    pulse(0);
    chk("R4 bus-off rx", rx_o, 1'b1);
    chk("R4 bus-off tx", tx_o, 1'b1);
    send_seq(5);
    for (int i = 0; i < 6; i++) send_bit(1'b1, 0);
    pulse(0);
    send_seq(1);
    chk("R4 restart mid recovery", rx_o, 1'b1);

    phase = "R5";
    send_seq(126);
    chk("R5 still waiting at 127", tx_o, 1'b1);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 0);
    @(negedge clk); strobe = 1; level = 1;
    @(negedge clk); strobe = 0;
    chk("R5 idle after 128 rx", rx_o, 1'b0);
    chk("R5 idle after 128 tx", tx_o, 1'b0);
    chk("R6 recovery pulse", rec_o, 1'b1);
    @(negedge clk);
    chk("R6 pulse one cycle", rec_o, 1'b0);

    phase = "R4";
    pulse(0);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 0);
    @(negedge clk); strobe = 1; level = 1; bus_off = 1;
    @(negedge clk); strobe = 0; bus_off = 0;
    send_seq(127);
    chk("R4 bus-off beats completion", rx_o, 1'b1);
    send_seq(1);
    chk("R5 second recovery idle", rx_o, 1'b0);
    cyc(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule